// File: doc/BRIEF.md
# Accessory Tray Link Master

This block runs the master side of a half-duplex, clock-synchronised serial link to accessory paper trays. Three wires make up the link: a shared open-drain data line, an active-low clock that only the master drives, and an active-low ready line that the tray pulls down when it has a reply prepared. A transaction starts when the user pulses `start` with a command byte. The upper nibble of that byte addresses one tray, and only that tray responds.

The master shifts the command out most significant bit first. It then lets go of the data line and waits for ready. A short wait is enforced before ready is accepted, and a long wait without ready ends the transaction with a timeout. When ready is seen, the master clocks in a reply byte, again most significant bit first, and presents it with a one-cycle `done` pulse. After every transaction the master stays busy through a mandatory quiet gap before it will accept another command.

All timing limits are set in nanoseconds or microseconds and converted to system clock cycles from the clock-frequency parameter.

Top module: `opt_link_master`

## Requirements
- R1: After reset the clock output is high, the data line is released (`sd_oe` = 0), and `busy` and `done` are low.
- R2: The command goes out most significant bit first. `sd_oe` = 1 pulls the line low for a 0 bit. The data stays unchanged while the clock is low, so a tray that samples on the rising clock edge receives the exact byte.
- R3: Each bit starts with a setup time of SETUP_NS with the clock high. The clock is then low for LOW_NS and high for HIGH_NS. At 1 MHz this gives 21 cycles low, and 41 cycles from a rising edge to the next falling edge within a byte.
- R4: From the last command bit until the end of the reply, the master never pulls the data line (`sd_oe` stays 0).
- R5: The master produces no reply clocks until ready (`rdy_n` = 0) is seen. Ready that arrives earlier than RDY_MIN_US after the command's final high phase is held off until that minimum has elapsed.
- R6: The reply is shifted in MSB first, with each bit sampled at the end of its clock-low phase. It appears on `reply` together with a single-cycle `done` and `timeout` = 0, after exactly 16 clock pulses for the whole transaction.
- R7: If ready does not come within RDY_MAX_US, `done` pulses with `timeout` = 1 and no reply clocks are issued (8 pulses in total).
- R8: `busy` stays high from the accepted start until GAP_US after `done`.
- R9: A `start` pulse while `busy` is high is ignored. It neither changes the command in progress nor begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| cmd | input | 8 | Command byte; bits 7:4 hold the tray address |
| busy | output | 1 | Transaction or quiet gap in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| timeout | output | 1 | Last transaction saw no ready |
| reply | output | 8 | Last reply byte received |
| sd_oe | output | 1 | Pull the shared data line low |
| sd_in | input | 1 | Level of the shared data line |
| sclk_n | output | 1 | Active-low serial clock |
| rdy_n | input | 1 | Active-low ready from the tray |

## Verification
The bench builds the block with CLK_MHZ = 1 and keeps the nominal time limits. That makes each bit phase, the ready window of 1300 to 3000 cycles, and the 3000-cycle quiet gap exact cycle counts that can be measured against the port edges. These settings keep a full reply transaction, an early-ready transaction, a timeout, and the gap all within a short run. At this frequency the 1.5 µs setup reduces to one cycle, so the 21-cycle low phase and the 41-cycle rise-to-fall spacing are the phase widths being checked.

// File: rtl/opt_link_master.sv
module opt_link_master #(
  parameter int CLK_MHZ    = 24,
  parameter int SETUP_NS   = 1500,
  parameter int LOW_NS     = 21000,
  parameter int HIGH_NS    = 40000,
  parameter int RDY_MIN_US = 1300,
  parameter int RDY_MAX_US = 3000,
  parameter int GAP_US     = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] cmd,
  output logic       busy,
  output logic       done,
  output logic       timeout,
  output logic [7:0] reply,
  output logic       sd_oe,
  input  logic       sd_in,
  output logic       sclk_n,
  input  logic       rdy_n
);

  localparam int SU_R   = CLK_MHZ * SETUP_NS / 1000;
  localparam int LO_R   = CLK_MHZ * LOW_NS / 1000;
  localparam int HI_R   = CLK_MHZ * HIGH_NS / 1000;
  localparam int SU_C   = SU_R > 0 ? SU_R : 1;
  localparam int LO_C   = LO_R > 0 ? LO_R : 1;
  localparam int HI_C   = HI_R > 0 ? HI_R : 1;
  localparam int RMIN_C = CLK_MHZ * RDY_MIN_US;
  localparam int RMAX_C = CLK_MHZ * RDY_MAX_US;
  localparam int GAP_C  = CLK_MHZ * GAP_US;
  localparam int BIG_A  = RMAX_C > GAP_C ? RMAX_C : GAP_C;
  localparam int BIG    = BIG_A > HI_C ? BIG_A : HI_C;
  localparam int CW     = $clog2(BIG + 1) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_TSU, S_TLO, S_THI, S_WAIT, S_RSU, S_RLO, S_RHI, S_GAP
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic [1:0]    rdy_s, sd_s;

  assign busy   = st != S_IDLE;
  assign sclk_n = !(st == S_TLO || st == S_RLO);
  assign sd_oe  = (st == S_TSU || st == S_TLO || st == S_THI) && !sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_s <= 2'b11;
      sd_s  <= 2'b11;
    end else begin
      rdy_s <= {rdy_s[0], rdy_n};
      sd_s  <= {sd_s[0], sd_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= 8'hFF;
      done    <= 1'b0;
      timeout <= 1'b0;
      reply   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          sh      <= cmd;
          bitn    <= 3'd7;
          cnt     <= CW'(SU_C - 1);
          timeout <= 1'b0;
          st      <= S_TSU;
        end
        S_TSU: if (cnt == '0) begin cnt <= CW'(LO_C - 1); st <= S_TLO; end
               else cnt <= cnt - 1'b1;
        S_TLO: if (cnt == '0) begin cnt <= CW'(HI_C - 1); st <= S_THI; end
               else cnt <= cnt - 1'b1;
        S_THI: if (cnt != '0) cnt <= cnt - 1'b1;
               else if (bitn == '0) begin sh <= 8'hFF; cnt <= '0; st <= S_WAIT; end
               else begin
                 sh   <= {sh[6:0], 1'b1};
                 bitn <= bitn - 1'b1;
                 cnt  <= CW'(SU_C - 1);
                 st   <= S_TSU;
               end
        S_WAIT: if (!rdy_s[1] && cnt >= CW'(RMIN_C)) begin
                  bitn <= 3'd7;
                  cnt  <= CW'(SU_C - 1);
                  st   <= S_RSU;
                end else if (cnt == CW'(RMAX_C - 1)) begin
                  timeout <= 1'b1;
                  done    <= 1'b1;
                  cnt     <= CW'(GAP_C - 1);
                  st      <= S_GAP;
                end else cnt <= cnt + 1'b1;
        S_RSU: if (cnt == '0) begin cnt <= CW'(LO_C - 1); st <= S_RLO; end
               else cnt <= cnt - 1'b1;
        S_RLO: if (cnt == '0) begin
                 reply <= {reply[6:0], sd_s[1]};
                 cnt   <= CW'(HI_C - 1);
                 st    <= S_RHI;
               end else cnt <= cnt - 1'b1;
        S_RHI: if (cnt != '0) cnt <= cnt - 1'b1;
               else if (bitn == '0) begin
                 done <= 1'b1;
                 cnt  <= CW'(GAP_C - 1);
                 st   <= S_GAP;
               end else begin
                 bitn <= bitn - 1'b1;
                 cnt  <= CW'(SU_C - 1);
                 st   <= S_RSU;
               end
        S_GAP: if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DATA_HELD_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_n && $past(!sclk_n)) |-> $stable(sd_oe)); // R2
  AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sd_oe && sclk_n)); // R4
  AST_NO_CLK_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |=> ($past(sclk_n) && !sd_oe)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_BUSY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R8
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done && st != S_GAP) |=> busy); // R9

endmodule

// File: tb/sim_opt_link_master.sv
module sim_opt_link_master;
  localparam int PERIOD = 10;
  localparam int LO = 21, HI = 40, SU = 1, RMIN = 1300, RMAX = 3000, GAP = 3000;
  localparam logic [3:0] TRAY_ID = 4'hA;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] cmd = 0;
  logic busy, done, timeout, sd_oe, sclk_n;
  logic [7:0] reply;
  logic t_oe = 0, rdy_n = 1;
  wire  sd_line = !(sd_oe || t_oe);

  int n_chk = 0, n_bad = 0, cyc = 0;

  opt_link_master #(.CLK_MHZ(1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .busy(busy), .done(done),
    .timeout(timeout), .reply(reply), .sd_oe(sd_oe), .sd_in(sd_line),
    .sclk_n(sclk_n), .rdy_n(rdy_n));

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic prev_s = 1;
  int phase = 0, ccount = 0, rcount = 0, dly = 0, rep_delay = 0;
  logic [7:0] cbits = 0, got_cmd = 0, rep_byte = 0;
  int falls = 0, last_fall = 0, last_rise = 0, low_w = 0, high_w = 0;
  int cmd_end = 0, first_rep_fall = 0, oe_bad = 0, oe_lowchg = 0, done_cyc = 0;
  logic prev_oe = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_s && !sclk_n) begin
        falls++; high_w = cyc - last_rise; last_fall = cyc;
        if (phase == 2) begin
          if (rcount == 0) first_rep_fall = cyc;
          t_oe = !rep_byte[7 - rcount];
        end
      end
      if (!prev_s && !sclk_n && sd_oe != prev_oe) oe_lowchg++;
      if (!prev_s && sclk_n) begin
        low_w = cyc - last_fall; last_rise = cyc;
        if (phase == 0) begin
          cbits = {cbits[6:0], sd_line}; ccount++;
          if (ccount == 8) begin
            got_cmd = cbits; cmd_end = cyc; ccount = 0;
            if (cbits[7:4] == TRAY_ID) begin phase = 1; dly = rep_delay; end
          end
        end else if (phase == 2) begin
          rcount++;
          if (rcount == 8) begin t_oe = 0; rdy_n = 1; phase = 0; end
        end
      end
      if (phase == 1) begin
        if (dly <= 0) begin rdy_n = 0; phase = 2; rcount = 0; end
        else dly--;
      end
      if (!rdy_n && sd_oe) oe_bad++;
      prev_s = sclk_n; prev_oe = sd_oe;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [7:0] c);
    @(negedge clk); start = 1; cmd = c;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin done_cyc = cyc; return; end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sclk_n === 1'b1, "R1 clock idle high", sclk_n, 1);
    chk(sd_oe === 1'b0 && sd_line === 1'b1, "R1 data released", sd_oe, 0);
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done low", busy, 0);
  endtask

  task automatic t_basic();
    falls = 0; oe_bad = 0; oe_lowchg = 0; rep_delay = 1500; rep_byte = 8'h3C;
    pulse_start(8'hA5);
    wait_done();
    chk(got_cmd == 8'hA5, "R2 command byte MSB first", got_cmd, 8'hA5);
    chk(oe_lowchg == 0, "R2 data steady while clock low", oe_lowchg, 0);
    chk(low_w == LO, "R3 clock low width", low_w, LO);
    chk(high_w == HI + SU, "R3 rise to fall spacing", high_w, HI + SU);
    chk(oe_bad == 0, "R4 released during reply", oe_bad, 0);
    chk(reply == 8'h3C, "R6 reply byte", reply, 8'h3C);
    chk(timeout == 1'b0, "R6 no timeout", timeout, 0);
    chk(falls == 16, "R6 clock pulse count", falls, 16);
    chk(busy == 1'b1, "R8 busy at done", busy, 1);
    wait_idle();
  endtask

  task automatic t_early_and_gap();
    int d;
    falls = 0; rep_delay = 5; rep_byte = 8'h81;
    pulse_start(8'hA0);
    wait_done();
    d = first_rep_fall - cmd_end;
    chk(d >= HI + RMIN && d <= HI + RMIN + 8, "R5 early ready held off", d, HI + RMIN);
    chk(reply == 8'h81, "R6 reply after early ready", reply, 8'h81);
    falls = 0;
    pulse_start(8'hAF);
    chk(falls == 0, "R9 start in gap ignored", falls, 0);
    wait_idle();
    d = cyc - done_cyc;
    chk(d >= GAP && d <= GAP + 4, "R8 quiet gap length", d, GAP);
    chk(falls == 0, "R9 no clocks from ignored start", falls, 0);
  endtask

  task automatic t_timeout();
    int d;
    falls = 0; rep_delay = 0;
    pulse_start(8'h51);
    wait_done();
    d = done_cyc - cmd_end;
    chk(timeout == 1'b1, "R7 timeout flag", timeout, 1);
    chk(falls == 8, "R7 no reply clocks", falls, 8);
    chk(d >= HI + RMAX && d <= HI + RMAX + 4, "R7 timeout delay", d, HI + RMAX);
    wait_idle();
  endtask

  task automatic t_busy_start();
    falls = 0; rep_delay = 1400; rep_byte = 8'h6E;
    pulse_start(8'hA3);
    repeat (150) @(negedge clk);
    pulse_start(8'hFF);
    wait_done();
    chk(got_cmd == 8'hA3, "R9 command unchanged by busy start", got_cmd, 8'hA3);
    chk(falls == 16, "R9 single transaction", falls, 16);
    chk(reply == 8'h6E && timeout == 1'b0, "R6 reply after busy start", reply, 8'h6E);
    wait_idle();
  endtask

  initial begin
    #(PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_early_and_gap();
    t_timeout();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule